// File: doc/BRIEF.md
# Multi-Lane Serial ADC Frame Receiver

This block receives conversion results from an analog-to-digital converter that streams its data over several serial lanes at once. The converter supplies its own data clock and a ready strobe that marks the first bit of each frame. On every falling edge of that data clock the receiver takes one bit from each lane, MSB first. It builds one 32-bit word per lane. Once the thirty-second bit has arrived, the three words are latched together as one frame.

The finished frame is handed to the system clock domain. A toggle flag crosses through a two-flop synchronizer. The system side then copies the held words into its output register and raises a one-cycle valid pulse. Some frames are cut short because the ready strobe returns before all bits have arrived. In that case the partial frame is discarded, a one-cycle error pulse is raised on the system side, and the new strobe starts a fresh frame.

With the default settings, a frame of 96 bits takes 32 data-clock periods instead of 96 on a single lane. This leaves plenty of margin at a 20 MHz data clock.

Top module: `adc_lane_rx`

## Requirements
- R1: While `rst_n` is low, `valid_o` and `err_o` are 0 and `frame_o` is all zeros.
- R2: A falling `dclk_i` edge on which `drdy_i` is 1 starts a frame. The lane bits taken on that edge become bit 31 (the MSB) of each lane word.
- R3: Lane bits are sampled only on falling `dclk_i` edges, MSB first. Lane k's completed word appears at `frame_o[32k+31:32k]`.
- R4: A frame completes on the 32nd falling edge counted from its start edge. `valid_o` rises on the third rising `sys_clk` edge after that falling edge and lasts exactly one `sys_clk` cycle. `frame_o` takes the new words in that same cycle.
- R5: `frame_o` does not change in any cycle in which `valid_o` is 0.
- R6: If `drdy_i` is 1 while a frame has between 1 and 31 bits received, the partial frame produces no `valid_o`. `err_o` pulses for one cycle with the R4 latency, and that edge starts a new frame.
- R7: If `drdy_i` is 1 on the falling edge right after a frame completes, no error is raised and both frames are delivered.
- R8: Lane bits that arrive while no frame is open, with `drdy_i` at 0, produce no `valid_o`, no `err_o` and no change of `frame_o`.
- R9: If `drdy_i` returns after exactly 31 bits of a frame, that frame is still treated as partial: it is dropped and `err_o` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock for the output side |
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| dclk_i | input | 1 | Data clock from the converter; bits are sampled on its falling edge |
| drdy_i | input | 1 | Ready strobe marking the first bit of a frame |
| lanes_i | input | 3 | Serial data lanes; bit k is lane k |
| frame_o | output | 96 | Last completed frame; lane k occupies bits 32k+31..32k |
| valid_o | output | 1 | One-cycle pulse when `frame_o` takes a new frame |
| err_o | output | 1 | One-cycle pulse when a partial frame was dropped |

## Verification
The bench covers frames that follow each other with no gap, a strobe returning after 10 bits and after 31 bits, and stray lane activity with no strobe. A design that miscounted the frame boundary would either raise an error on back-to-back frames or accept a 31-bit frame as complete. A design that kept a partial frame would show its bits in `frame_o`. A design that shifted in stray bits or lost the MSB would show its mistake as a wrong word or an unexpected valid pulse. Each frame's arrival time is predicted from the falling data-clock edge, so a synchronizer stage too many or too few shows up as a valid or error pulse one cycle off.

// File: rtl/adc_rx_pkg.sv
`timescale 1ns/1ps
package adc_rx_pkg;
    localparam int DEF_LANES  = 3;
    localparam int DEF_WORD_W = 32;
    localparam int DEF_SYNC   = 2;

    // per-edge command from the frame controller to every lane shifter
    typedef struct packed {
        logic load;   // first bit of a frame
        logic shift;  // continuing bit
        logic last;   // final bit: latch word
    } lane_cmd_t;
endpackage

// File: rtl/adc_rx_frame_ctrl.sv
`timescale 1ns/1ps
module adc_rx_frame_ctrl
    import adc_rx_pkg::*;
#(
    parameter int WORD_W = DEF_WORD_W
) (
    input  logic      dclk_i,
    input  logic      rst_n,
    input  logic      drdy_i,
    output lane_cmd_t cmd_o,
    output logic      done_tgl_o,
    output logic      err_tgl_o
);
    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WORD_W - 1);

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
        logic             done_tgl;
        logic             err_tgl;
    } ctrl_st_t;

    ctrl_st_t  st_d, st_q;
    lane_cmd_t cmd_d;

    always_comb begin
        st_d  = st_q;
        cmd_d = '0;
        if (drdy_i) begin
            // new frame; an open frame is abandoned (R6, R9)
            cmd_d.load  = 1'b1;
            st_d.active = 1'b1;
            st_d.cnt    = CNT_W'(1);
            if (st_q.active) begin
                st_d.err_tgl = ~st_q.err_tgl;
            end
        end else if (st_q.active) begin
            cmd_d.shift = 1'b1;
            st_d.cnt    = st_q.cnt + CNT_W'(1);
            if (st_q.cnt == LAST_CNT) begin
                cmd_d.last    = 1'b1;
                st_d.active   = 1'b0;
                st_d.cnt      = '0;
                st_d.done_tgl = ~st_q.done_tgl;
            end
        end
    end

    always_ff @(negedge dclk_i or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_o      = cmd_d;
    assign done_tgl_o = st_q.done_tgl;
    assign err_tgl_o  = st_q.err_tgl;
endmodule

// File: rtl/adc_rx_lane_deser.sv
`timescale 1ns/1ps
module adc_rx_lane_deser
    import adc_rx_pkg::*;
#(
    parameter int WORD_W = DEF_WORD_W
) (
    input  logic              dclk_i,
    input  logic              rst_n,
    input  logic              bit_i,
    input  lane_cmd_t         cmd_i,
    output logic [WORD_W-1:0] word_o
);
    typedef struct packed {
        logic [WORD_W-2:0] sh;    // bits received so far, last one excluded
        logic [WORD_W-1:0] word;  // last completed word
    } deser_st_t;

    deser_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cmd_i.load) begin
            st_d.sh = {{(WORD_W-2){1'b0}}, bit_i};
        end else if (cmd_i.shift) begin
            st_d.sh = {st_q.sh[WORD_W-3:0], bit_i};
        end
        if (cmd_i.last) begin
            st_d.word = {st_q.sh, bit_i};
        end
    end

    always_ff @(negedge dclk_i or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o = st_q.word;
endmodule

// File: rtl/adc_rx_tgl_sync.sv
`timescale 1ns/1ps
module adc_rx_tgl_sync
    import adc_rx_pkg::*;
#(
    parameter int STAGES = DEF_SYNC
) (
    input  logic clk_i,
    input  logic rst_n,
    input  logic tgl_i,
    output logic pulse_o
);
    // STAGES synchronizer flops plus one history flop for edge detection
    logic [STAGES:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-1:0], tgl_i};
    end

    always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign pulse_o = chain_q[STAGES] ^ chain_q[STAGES-1];
endmodule

// File: rtl/adc_lane_rx.sv
`timescale 1ns/1ps
module adc_lane_rx
    import adc_rx_pkg::*;
#(
    parameter int NUM_LANES   = DEF_LANES,
    parameter int WORD_W      = DEF_WORD_W,
    parameter int SYNC_STAGES = DEF_SYNC
) (
    input  logic                        sys_clk,
    input  logic                        rst_n,
    input  logic                        dclk_i,
    input  logic                        drdy_i,
    input  logic [NUM_LANES-1:0]        lanes_i,
    output logic [NUM_LANES*WORD_W-1:0] frame_o,
    output logic                        valid_o,
    output logic                        err_o
);
    localparam int FRAME_W = NUM_LANES * WORD_W;
    localparam int N_EVT   = 2;  // index 0: frame done, index 1: frame error

    lane_cmd_t          cmd;
    logic               done_tgl, err_tgl;
    logic [FRAME_W-1:0] held_frame;
    logic [N_EVT-1:0]   evt_tgl, evt_pulse;

    adc_rx_frame_ctrl #(.WORD_W(WORD_W)) i_ctrl (
        .dclk_i     (dclk_i),
        .rst_n      (rst_n),
        .drdy_i     (drdy_i),
        .cmd_o      (cmd),
        .done_tgl_o (done_tgl),
        .err_tgl_o  (err_tgl)
    );

    for (genvar ln = 0; ln < NUM_LANES; ln++) begin : g_lane
        adc_rx_lane_deser #(.WORD_W(WORD_W)) i_deser (
            .dclk_i (dclk_i),
            .rst_n  (rst_n),
            .bit_i  (lanes_i[ln]),
            .cmd_i  (cmd),
            .word_o (held_frame[ln*WORD_W +: WORD_W])
        );
    end

    assign evt_tgl = {err_tgl, done_tgl};

    for (genvar ev = 0; ev < N_EVT; ev++) begin : g_sync
        adc_rx_tgl_sync #(.STAGES(SYNC_STAGES)) i_sync (
            .clk_i   (sys_clk),
            .rst_n   (rst_n),
            .tgl_i   (evt_tgl[ev]),
            .pulse_o (evt_pulse[ev])
        );
    end

    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic               valid;
        logic               err;
    } out_st_t;

    out_st_t out_d, out_q;

    always_comb begin
        out_d       = out_q;
        out_d.valid = evt_pulse[0];
        out_d.err   = evt_pulse[1];
        if (evt_pulse[0]) begin
            // held words are stable: next change is a full frame away
            out_d.frame = held_frame;
        end
    end

    always_ff @(posedge sys_clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign frame_o = out_q.frame;
    assign valid_o = out_q.valid;
    assign err_o   = out_q.err;
endmodule

// File: rtl/adc_lane_rx_chk.sv
`timescale 1ns/1ps
module adc_lane_rx_chk #(
    parameter int FRAME_W = 96
) (
    input logic               sys_clk,
    input logic               rst_n,
    input logic [FRAME_W-1:0] frame_o,
    input logic               valid_o,
    input logic               err_o
);
    always @(negedge sys_clk) begin
        if (!rst_n) begin
            a_r1_reset_quiet: assert (!valid_o && !err_o && frame_o == '0)
                else $error("R1: outputs active during reset");
        end
    end

    a_r4_valid_single: assert property (@(posedge sys_clk) disable iff (!rst_n)
        valid_o |=> !valid_o)
        else $error("R4: valid longer than one cycle");

    a_r5_frame_hold: assert property (@(posedge sys_clk) disable iff (!rst_n)
        !valid_o |-> $stable(frame_o))
        else $error("R5: frame changed without valid");

    a_r6_err_single: assert property (@(posedge sys_clk) disable iff (!rst_n)
        err_o |=> !err_o)
        else $error("R6: error longer than one cycle");

    a_r6_err_valid_apart: assert property (@(posedge sys_clk) disable iff (!rst_n)
        !(err_o && valid_o))
        else $error("R6: error and valid together");
endmodule

bind adc_lane_rx adc_lane_rx_chk #(.FRAME_W(NUM_LANES * WORD_W)) i_adc_lane_rx_chk (
    .sys_clk (sys_clk),
    .rst_n   (rst_n),
    .frame_o (frame_o),
    .valid_o (valid_o),
    .err_o   (err_o)
);

// File: tb/test_adc_lane_rx.sv
`timescale 1ns/1ps
module test_adc_lane_rx;
    logic        sys_clk = 1'b0;
    logic        dclk    = 1'b1;
    logic        rst_n;
    logic        drdy    = 1'b0;
    logic [2:0]  lanes   = '0;
    logic [95:0] frame_o;
    logic        valid_o, err_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit mon_en   = 1'b0;
    bit in_frame = 1'b0;
    int seed     = 7;

    longint      exp_vt[$];
    logic [95:0] exp_vf[$];
    longint      exp_et[$];
    logic [95:0] last_frame = '0;

    adc_lane_rx i_adc_lane_rx (
        .sys_clk (sys_clk),
        .rst_n   (rst_n),
        .dclk_i  (dclk),
        .drdy_i  (drdy),
        .lanes_i (lanes),
        .frame_o (frame_o),
        .valid_o (valid_o),
        .err_o   (err_o)
    );

    always #2.5 sys_clk = ~sys_clk;  // 200 MHz
    always #25  dclk    = ~dclk;     // 20 MHz data clock

    task automatic check(input bit ok, input string tag,
                         input logic [95:0] act, input logic [95:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at %0t act=%h exp=%h", tag, $time, act, exp);
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    endtask

    function automatic logic [95:0] pattern(input int s);
        logic [95:0] f;
        for (int l = 0; l < 3; l++) begin
            f[l*32 +: 32] = 32'(s * 32'h9E3779B9 + (l + 1) * 32'h7F4A7C15);
        end
        return f;
    endfunction

    // Drive nbits of frame f (MSB first per lane), optionally with the strobe.
    task automatic send(input logic [95:0] f, input int nbits, input bit with_rdy);
        for (int i = 0; i < nbits; i++) begin
            longint t;
            @(posedge dclk);
            drdy = with_rdy && (i == 0);
            for (int l = 0; l < 3; l++) lanes[l] = f[l*32 + 31 - i];
            @(negedge dclk);
            t = $time;
            if (drdy) begin
                if (in_frame) exp_et.push_back(t + 15);  // R6, R9
                in_frame = 1'b1;
            end
            if (in_frame && with_rdy && i == 31) begin
                exp_vt.push_back(t + 15);                // R4
                exp_vf.push_back(f);
                in_frame = 1'b0;
            end
            #1 drdy = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge dclk);
            drdy  = 1'b0;
            lanes = 3'(i * 5 + 3);
        end
    endtask

    // cycle-by-cycle comparison against the expectation queues
    always @(negedge sys_clk) begin
        if (mon_en) begin
            bit ev, ee;
            while (exp_vt.size() > 0 && exp_vt[0] < $time) begin
                void'(exp_vt.pop_front()); void'(exp_vf.pop_front());
            end
            while (exp_et.size() > 0 && exp_et[0] < $time) void'(exp_et.pop_front());
            ev = (exp_vt.size() > 0 && exp_vt[0] == $time);
            ee = (exp_et.size() > 0 && exp_et[0] == $time);
            if (ev) begin
                last_frame = exp_vf[0];
                void'(exp_vt.pop_front()); void'(exp_vf.pop_front());
            end
            if (ee) void'(exp_et.pop_front());
            check(valid_o === ev, "R4 valid timing", 96'(valid_o), 96'(ev));
            check(err_o === ee, "R6 error pulse timing", 96'(err_o), 96'(ee));
            check(frame_o === last_frame, "R3/R5 frame content", frame_o, last_frame);
        end
    end

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        rst_n = 1'b1;
        #1 rst_n = 1'b0;
        lanes = 3'b111;
        #11;
        check(valid_o === 1'b0, "R1 reset valid", 96'(valid_o), 96'd0);
        check(err_o === 1'b0, "R1 reset err", 96'(err_o), 96'd0);
        check(frame_o === '0, "R1 reset frame", frame_o, '0);
        #1 rst_n = 1'b1;
        mon_en = 1'b1;

        // R8: stray bits with no strobe before any frame
        idle(40);
        // R2/R3: single frames of distinct shapes
        send({32'hFFFF_FFFF, 32'h0000_0000, 32'h8000_0001}, 32, 1'b1);
        idle(3);
        send({32'hAAAA_5555, 32'h1234_5678, 32'hDEAD_BEEF}, 32, 1'b1);
        // R7: back-to-back frames
        send(pattern(1), 32, 1'b1);
        send(pattern(2), 32, 1'b1);
        // R8: stray bits after a completed frame
        idle(45);
        // R6: strobe returns after 10 bits
        send(pattern(3), 10, 1'b1);
        send(pattern(4), 32, 1'b1);
        idle(5);
        // R9: strobe returns after 31 bits
        send(pattern(5), 31, 1'b1);
        send(pattern(6), 32, 1'b1);
        idle(4);
        // R6: strobe on the second bit
        send(pattern(7), 1, 1'b1);
        send(pattern(8), 32, 1'b1);
        for (int k = 0; k < 6; k++) begin
            send(pattern(seed + k * 13), 32, 1'b1);
            idle(k);
        end
        idle(6);
        repeat (20) @(posedge sys_clk);
        @(negedge sys_clk);
        check(exp_vt.size() == 0, "R4 all frames delivered", 96'(exp_vt.size()), 96'd0);
        check(exp_et.size() == 0, "R6 all errors reported", 96'(exp_et.size()), 96'd0);
        report();
        $finish;
    end
endmodule